// File: doc/BRIEF.md
# Triple-Counter Event Timer

This block holds three independent counters behind a simple word-addressed register bus. Each counter has a count value, a reload value and two compare values. It steps up or down on every clock or on each rising edge of an external tick, depending on one control bit. When a step lands on a compare value, or when the counter wraps, the block latches an event bit in a shared status word. One interrupt line reports every pending event that is not masked and whose timer has its interrupt enable set.

Software typically uses one counter as a free-running time base. It uses a second counter for periodic or one-shot wake-ups. For a periodic wake-up, it either programs the reload value so that the counter wraps at the wanted rate, or places a compare value on the path the counter takes. The status word is cleared by writing ones to the bits to be cleared, so no read-modify-write cycle is needed.

Top module: `tri_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero except the mask word, which reads 0x1FF, and irq is low.
- R2: Registers are word-aligned. Timer n has count at 0x10*n, reload at 0x10*n+4, compare-1 at 0x10*n+8 and compare-2 at 0x10*n+0xC. Control is at 0x30 (12 bits), status at 0x34 (9 bits) and mask at 0x38 (9 bits). Unused upper bits read zero. Unmapped or unaligned addresses read zero, and writes to them have no effect.
- R3: Control bits for timer n are: run at bit 3n, external-tick select at bit 3n+1 and interrupt enable at bit 3n+2. The direction bit of timer n is at bit 9+n, where 1 means count up. A timer whose run bit is 0 keeps its count unchanged.
- R4: When counting up, each step adds one. A step taken at 0xFFFFFFFF loads the reload value instead and sets status bit 3n+2.
- R5: When counting down, each step subtracts one. A step taken at 0 loads the reload value instead and sets status bit 3n+2.
- R6: A step that gives the counter a value equal to compare-1 sets status bit 3n. A step that gives a value equal to compare-2 sets status bit 3n+1.
- R7: With external-tick select set, the counter takes exactly one step for each rising edge of ext_tick. The edge is seen through a two-stage synchronizer. A level held high gives no further steps.
- R8: Writing a 1 to a status bit clears it. Writing 0 leaves the bit unchanged. An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R9: irq is high exactly when some status bit is set, its mask bit is 0, and the run-independent interrupt-enable bit of its timer is 1.
- R10: A bus write to a count register takes priority over a step in the same cycle. That write raises no compare or wrap event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | Asynchronous external tick; rising edges step selected timers |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is a status clear that lands in the same clock as a fresh event on the same bit. The stimulus sets up an up-counter three steps short of its wrap. It then times the status write so that its single write cycle is the very cycle in which the wrap happens. Write-over-step priority is reached the same way: the count is rewritten while the timer runs, onto a value that matches compare-1. External-tick behaviour is exercised by holding ext_tick high for several cycles, which shows that a level gives only one step.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

    // events and control fields per timer
    localparam int EVT_PER_TMR = 3;
    // each timer owns a 16-byte window of four words
    localparam int SLOT_SHIFT  = 4;

    typedef enum logic [1:0] {
        SLOT_COUNT  = 2'd0,
        SLOT_RELOAD = 2'd1,
        SLOT_CMP1   = 2'd2,
        SLOT_CMP2   = 2'd3
    } slot_e;

    // bit 0 compare-1, bit 1 compare-2, bit 2 wrap
    typedef struct packed {
        logic wrap;
        logic hit2;
        logic hit1;
    } tmr_evt_t;

    // bit 0 run, bit 1 external tick select, bit 2 interrupt enable
    typedef struct packed {
        logic irq_en;
        logic ext_sel;
        logic run;
    } tmr_ctl_t;

    function automatic logic [EVT_PER_TMR-1:0] spread(input logic b);
        return {EVT_PER_TMR{b}};
    endfunction

endpackage

// File: rtl/tri_timer_tick.sv
module tri_timer_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_tick,
    output logic tick_pulse
);
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], ext_tick};
    end

    assign tick_pulse = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_pulse |=> !tick_pulse) else $error("tick pulse longer than one cycle"); // R7

endmodule

// File: rtl/tri_timer_cnt.sv
module tri_timer_cnt import tri_timer_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             count_up,
    input  logic [3:0]       wr_slot,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cmp1,
    output logic [CNT_W-1:0] cmp2,
    output tmr_evt_t         evt
);
    localparam int IX_CNT = int'(SLOT_COUNT);
    localparam int IX_RLD = int'(SLOT_RELOAD);
    localparam int IX_C1  = int'(SLOT_CMP1);
    localparam int IX_C2  = int'(SLOT_CMP2);

    logic [CNT_W-1:0] cnt_q, rld_q, c1_q, c2_q, cnt_nx;
    logic             at_end, step;

    always_comb begin
        at_end = count_up ? (cnt_q == '1) : (cnt_q == '0);
        if (at_end)        cnt_nx = rld_q;
        else if (count_up) cnt_nx = cnt_q + 1'b1;
        else               cnt_nx = cnt_q - 1'b1;
        step     = advance && !wr_slot[IX_CNT];
        evt.hit1 = step && (cnt_nx == c1_q);
        evt.hit2 = step && (cnt_nx == c2_q);
        evt.wrap = step && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            c1_q  <= '0;
            c2_q  <= '0;
        end else begin
            if (wr_slot[IX_CNT])  cnt_q <= wdata;
            else if (advance)     cnt_q <= cnt_nx;
            if (wr_slot[IX_RLD])  rld_q <= wdata;
            if (wr_slot[IX_C1])   c1_q  <= wdata;
            if (wr_slot[IX_C2])   c2_q  <= wdata;
        end
    end

    assign count  = cnt_q;
    assign reload = rld_q;
    assign cmp1   = c1_q;
    assign cmp2   = c2_q;

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && count_up && !wr_slot[IX_CNT] && cnt_q != '1)
        |=> cnt_q == $past(cnt_q) + 1'b1) else $error("up step wrong"); // R4

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !count_up && !wr_slot[IX_CNT] && cnt_q != '0)
        |=> cnt_q == $past(cnt_q) - 1'b1) else $error("down step wrong"); // R5

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (advance && !wr_slot[IX_CNT] && !wr_slot[IX_RLD] &&
         ((count_up && cnt_q == '1) || (!count_up && cnt_q == '0)))
        |=> cnt_q == $past(rld_q)) else $error("wrap did not reload"); // R4

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!advance && !wr_slot[IX_CNT]) |=> $stable(cnt_q)) else $error("idle counter moved"); // R3

endmodule

// File: rtl/tri_timer_irq.sv
module tri_timer_irq import tri_timer_pkg::*; #(
    parameter int NUM_TMR = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_stat,
    input  logic                       wr_mask,
    input  logic [EVT_PER_TMR*NUM_TMR-1:0] wdata,
    input  logic [EVT_PER_TMR*NUM_TMR-1:0] evt_in,
    input  logic [NUM_TMR-1:0]         irq_en,
    output logic [EVT_PER_TMR*NUM_TMR-1:0] status,
    output logic [EVT_PER_TMR*NUM_TMR-1:0] mask,
    output logic                       irq
);
    localparam int SW = EVT_PER_TMR * NUM_TMR;

    logic [SW-1:0] stat_q, mask_q, en_vec, clr;

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_en
        assign en_vec[EVT_PER_TMR*n +: EVT_PER_TMR] = spread(irq_en[n]);
    end

    assign clr = wr_stat ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= (stat_q & ~clr) | evt_in;
            if (wr_mask) mask_q <= wdata;
        end
    end

    assign status = stat_q;
    assign mask   = mask_q;
    assign irq    = |(stat_q & ~mask_q & en_vec);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((stat_q & $past(evt_in)) == $past(evt_in))) else $error("event lost"); // R8

    AST_W1C: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> ((stat_q & $past(wdata & ~evt_in)) == '0)) else $error("clear ignored"); // R8

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_stat && evt_in == '0) |=> $stable(stat_q)) else $error("status changed alone"); // R8

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q != '0)) else $error("irq without pending event"); // R9

endmodule

// File: rtl/tri_timer.sv
module tri_timer import tri_timer_pkg::*; #(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int SW    = EVT_PER_TMR * NUM_TMR;
    localparam int CTL_W = (EVT_PER_TMR + 1) * NUM_TMR;
    localparam int IDX_W = ADDR_W - SLOT_SHIFT;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_TMR << SLOT_SHIFT);
    localparam logic [ADDR_W-1:0] A_STAT = A_CTRL + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_MASK = A_CTRL + ADDR_W'(8);

    logic             aligned, tick_pulse;
    logic [IDX_W-1:0] slot_idx;
    slot_e            slot_sel;
    logic [CTL_W-1:0] ctl_q;
    logic [SW-1:0]    evt_all, stat_v, mask_v;
    logic [NUM_TMR-1:0] ie_v;
    logic [CNT_W-1:0] cnt_a [NUM_TMR];
    logic [CNT_W-1:0] rld_a [NUM_TMR];
    logic [CNT_W-1:0] c1_a  [NUM_TMR];
    logic [CNT_W-1:0] c2_a  [NUM_TMR];

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign slot_idx = bus_addr[ADDR_W-1:SLOT_SHIFT];
    assign slot_sel = slot_e'(bus_addr[SLOT_SHIFT-1:2]);

    always_ff @(posedge clk) begin
        if (rst)                                      ctl_q <= '0;
        else if (bus_wr && aligned && bus_addr == A_CTRL) ctl_q <= bus_wdata[CTL_W-1:0];
    end

    tri_timer_tick #(.SYNC_STAGES(2)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .ext_tick   (ext_tick),
        .tick_pulse (tick_pulse)
    );

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
        logic [3:0] wr_n;
        tmr_ctl_t   ctl_n;
        tmr_evt_t   evt_n;
        logic       up_n, adv_n;

        assign ctl_n = ctl_q[EVT_PER_TMR*n +: EVT_PER_TMR];
        assign up_n  = ctl_q[EVT_PER_TMR*NUM_TMR + n];
        assign adv_n = ctl_n.run && (ctl_n.ext_sel ? tick_pulse : 1'b1);

        always_comb begin
            wr_n = '0;
            if (bus_wr && aligned && slot_idx == IDX_W'(n)) wr_n[slot_sel] = 1'b1;
        end

        tri_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .advance  (adv_n),
            .count_up (up_n),
            .wr_slot  (wr_n),
            .wdata    (bus_wdata),
            .count    (cnt_a[n]),
            .reload   (rld_a[n]),
            .cmp1     (c1_a[n]),
            .cmp2     (c2_a[n]),
            .evt      (evt_n)
        );

        assign evt_all[EVT_PER_TMR*n +: EVT_PER_TMR] = evt_n;
        assign ie_v[n] = ctl_n.irq_en;
    end

    tri_timer_irq #(.NUM_TMR(NUM_TMR)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_stat (bus_wr && aligned && bus_addr == A_STAT),
        .wr_mask (bus_wr && aligned && bus_addr == A_MASK),
        .wdata   (bus_wdata[SW-1:0]),
        .evt_in  (evt_all),
        .irq_en  (ie_v),
        .status  (stat_v),
        .mask    (mask_v),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (bus_addr == A_CTRL)      bus_rdata = CNT_W'(ctl_q);
            else if (bus_addr == A_STAT) bus_rdata = CNT_W'(stat_v);
            else if (bus_addr == A_MASK) bus_rdata = CNT_W'(mask_v);
            else begin
                for (int n = 0; n < NUM_TMR; n++) begin
                    if (slot_idx == IDX_W'(n)) begin
                        case (slot_sel)
                            SLOT_COUNT:  bus_rdata = cnt_a[n];
                            SLOT_RELOAD: bus_rdata = rld_a[n];
                            SLOT_CMP1:   bus_rdata = c1_a[n];
                            default:     bus_rdata = c2_a[n];
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: tb/tri_timer_test.sv
`timescale 1ns/1ps
module tri_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tri_timer uut (
        .clk(clk), .rst(rst), .ext_tick(ext_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {address, write data, expected read-back}
    localparam logic [71:0] VEC [12] = '{
        {8'h00, 32'h1234_5678, 32'h1234_5678},
        {8'h04, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
        {8'h08, 32'h0000_0010, 32'h0000_0010},
        {8'h0C, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {8'h10, 32'h0BAD_F00D, 32'h0BAD_F00D},
        {8'h18, 32'h8000_0001, 32'h8000_0001},
        {8'h24, 32'h00C0_FFEE, 32'h00C0_FFEE},
        {8'h2C, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
        {8'h30, 32'hFFFF_F036, 32'h0000_0036},
        {8'h30, 32'hFFFF_FE00, 32'h0000_0E00},
        {8'h38, 32'hFFFF_FE00, 32'h0000_0000},
        {8'h3C, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.01;
        check(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        #0.01;
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        report();
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset values
        for (int a = 0; a < 16; a++) begin
            if (a == 14) read_chk("R1 mask reset", 8'(a * 4), 32'h1FF);
            else         read_chk("R1 register reset", 8'(a * 4), 32'h0);
        end
        irq_chk("R1 irq low", 1'b0);
        @(negedge clk);

        // R2: table of write / read-back vectors
        for (int i = 0; i < 12; i++) begin
            bus_write(VEC[i][71:64], VEC[i][63:32]);
            read_chk("R2 read-back", VEC[i][71:64], VEC[i][31:0]);
        end
        bus_write(8'h01, 32'h0000_DEAD);
        read_chk("R2 unaligned write ignored", 8'h00, 32'h1234_5678);
        read_chk("R2 unaligned read zero", 8'h01, 32'h0);

        // R4 R6 R8: up count, compare-2, wrap, clear racing an event
        do_reset();
        bus_write(8'h04, 32'hFFFF_FFFD);
        bus_write(8'h00, 32'hFFFF_FFFD);
        bus_write(8'h0C, 32'hFFFF_FFFE);
        bus_write(8'h30, 32'h0000_0201);
        @(negedge clk);
        @(negedge clk);
        read_chk("R4 up count", 8'h00, 32'hFFFF_FFFF);
        read_chk("R6 compare-2 event", 8'h34, 32'h0000_0002);
        bus_write(8'h34, 32'h0000_0006);
        read_chk("R4 wrap reload", 8'h00, 32'hFFFF_FFFD);
        read_chk("R8 event beats clear", 8'h34, 32'h0000_0004);
        bus_write(8'h30, 32'h0);
        repeat (3) @(negedge clk);
        read_chk("R3 stopped counter frozen", 8'h00, 32'hFFFF_FFFE);
        read_chk("R6 compare-2 again", 8'h34, 32'h0000_0006);
        bus_write(8'h34, 32'h0);
        read_chk("R8 zero write keeps status", 8'h34, 32'h0000_0006);
        bus_write(8'h34, 32'h0000_0006);
        read_chk("R8 write-one clears", 8'h34, 32'h0);

        // R5 R6 R9: timer 1 down count, compare-1, wrap, irq gating
        do_reset();
        bus_write(8'h14, 32'h2);
        bus_write(8'h10, 32'h2);
        bus_write(8'h1C, 32'h55);
        bus_write(8'h30, 32'h0000_0008);
        @(negedge clk);
        @(negedge clk);
        read_chk("R5 down count", 8'h10, 32'h0);
        read_chk("R6 compare-1 event", 8'h34, 32'h0000_0008);
        @(negedge clk);
        read_chk("R5 down wrap reload", 8'h10, 32'h2);
        read_chk("R5 down wrap event", 8'h34, 32'h0000_0028);
        bus_write(8'h30, 32'h0000_0020);
        read_chk("R3 stop after last step", 8'h10, 32'h1);
        irq_chk("R9 all masked", 1'b0);
        bus_write(8'h38, 32'h1F7);
        irq_chk("R9 compare-1 unmasked", 1'b1);
        bus_write(8'h38, 32'h1DF);
        irq_chk("R9 wrap unmasked", 1'b1);
        bus_write(8'h34, 32'h20);
        irq_chk("R9 pending bit masked", 1'b0);
        read_chk("R8 partial clear", 8'h34, 32'h0000_0008);
        bus_write(8'h38, 32'h1F7);
        bus_write(8'h30, 32'h0);
        irq_chk("R9 enable off", 1'b0);

        // R7: external tick on timer 2
        do_reset();
        bus_write(8'h30, 32'h0000_08C0);
        repeat (5) @(negedge clk);
        read_chk("R7 no tick no step", 8'h20, 32'h0);
        ext_tick = 1'b1;
        repeat (6) @(negedge clk);
        read_chk("R7 one step per edge", 8'h20, 32'h1);
        ext_tick = 1'b0;
        repeat (4) @(negedge clk);
        ext_tick = 1'b1;
        repeat (4) @(negedge clk);
        read_chk("R7 second edge", 8'h20, 32'h2);

        // R10: write over a running step, then compare-1 by stepping
        do_reset();
        bus_write(8'h08, 32'h100);
        bus_write(8'h0C, 32'h55);
        bus_write(8'h30, 32'h0000_0201);
        bus_write(8'h00, 32'h100);
        read_chk("R10 write wins", 8'h00, 32'h100);
        read_chk("R10 no event from write", 8'h34, 32'h0);
        @(negedge clk);
        read_chk("R10 steps after write", 8'h00, 32'h101);
        bus_write(8'h08, 32'h105);
        repeat (3) @(negedge clk);
        read_chk("R6 compare-1 while up", 8'h00, 32'h105);
        read_chk("R6 compare-1 status", 8'h34, 32'h1);

        report();
        $finish;
    end
endmodule